// File: doc/BRIEF.md
# Delayed-LMS Acoustic Feedback Canceller

This block is an adaptive FIR filter that removes the copy of the output signal that leaks back into the microphone path. It takes one signed microphone sample on every clock that carries a valid strobe. It produces an estimate of the leaked component and an error sample, which is the input minus that estimate. There is no external reference input. The error sample is delayed by a fixed compensation line and fed back, unscaled, as the signal the filter convolves.

The datapath is fully parallel: twelve identical tap units, each with its own coefficient. Each tap forms its filter product and adds it into a partial-sum chain that is registered between neighbouring taps. Each tap also adapts its own coefficient. The adaptation follows the delayed-LMS rule: the error and the reference values used in an update are older than the current sample by the tap count. Because of this, the path inside a tap never grows with the filter length.

The step size is a power of two, set as a right shift of the update product. It is taken from a pin while reset is asserted and then held for the whole run.

Top module: `dlms_canceller`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every coefficient, every history entry and every partial sum to zero. After that edge est_o and err_o read 0 and out_valid reads 0.
- R2: For each accepted sample x(n), err_o equals x(n) minus the estimate y(n), saturated to [-128, 127]. Both values appear on err_o and est_o in the cycle after the sample is accepted.
- R3: The signal the filter convolves is u(n) = e(n-22): the filter's own error from 22 accepted samples earlier, with gain 1 and no scaling. It is zero for the first 22 samples after reset.
- R4: Coefficients are signed with 7 fraction bits. Tap k forms p_k = rnd(w_k * u, 7) in the cycle it sees u. The estimate is y(n) = p_0(n) + s_1, where s_k = p_k + s_(k+1) is the partial sum registered one accepted sample earlier and s_11 = p_11. Every addition saturates, so y(n) is the sum over k of taps evaluated k samples earlier.
- R5: After each accepted sample n, coefficient k becomes sat(w_k + rnd(e(n-12) * u(n-12-k), 7 + mu)). Here mu is the step shift, giving a step size of 2^-mu.
- R6: rnd(v, s) adds 2^(s-1) to the full-precision product, shifts it right arithmetically by s bits, and saturates the result to 8-bit signed. Products at the extremes, such as -128 * -128, clamp instead of wrapping.
- R7: When in_valid is low at a clock edge, nothing advances. est_o and err_o keep their values and out_valid is 0 in the following cycle.
- R8: Counting accepted samples from index 0 after reset, out_valid is 1 in the cycle after sample 11 and after every later accepted sample. It is 0 after samples 0 to 10.
- R9: step_shift is sampled only while rst is high. Changing it afterwards has no effect on est_o or err_o.
- R10: A new sample is accepted on every clock edge where in_valid is high, including back-to-back edges, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per sample slot |
| rst | input | 1 | Synchronous reset, active high; also loads the step shift |
| in_valid | input | 1 | The sample on in_sample is taken at this edge |
| in_sample | input | 8 | Signed microphone sample |
| step_shift | input | 3 | Step size as a right-shift amount, captured during reset |
| est_o | output | 8 | Signed estimate of the feedback component |
| err_o | output | 8 | Signed error: input minus estimate, saturated |
| out_valid | output | 1 | est_o and err_o belong to a sample past the fill phase |

## Verification
The bound checker watches, on every cycle, four properties that need only the ports: the cleared outputs after reset, error consistency with the previous input and the current estimate, output hold during idle slots, and the exact sample at which out_valid first rises. The numerical behaviour of the adaptation cannot be seen from one cycle of port values. This covers the 22-sample feedback delay, the 12-sample update delay, the transposed partial-sum timing, the rounding and saturation, and the fact that the step shift is ignored after reset. Only the bench's scenarios show these, by comparing every output with an independent sample-level model under several step sizes, extreme inputs, idle gaps and a reset in the middle of a run.

// File: rtl/dlms_pkg.sv
`timescale 1ns/1ps
package dlms_pkg;

    // Sample, coefficient and error width
    localparam int DW      = 8;
    // Fraction bits of a coefficient
    localparam int FRAC    = DW - 1;
    localparam int SMP_MAX = (1 << (DW - 1)) - 1;
    localparam int SMP_MIN = -(1 << (DW - 1));

    typedef logic signed [DW-1:0] smp_t;

    // Clamp a wide signed value to the sample range
    function automatic smp_t sat_dw(input logic signed [31:0] v);
        smp_t r;
        if (v > SMP_MAX) begin
            r = smp_t'(SMP_MAX);
        end else if (v < SMP_MIN) begin
            r = smp_t'(SMP_MIN);
        end else begin
            r = v[DW-1:0];
        end
        return r;
    endfunction

    // Round to nearest (half up) and shift right arithmetically by sh (sh >= 1)
    function automatic logic signed [31:0] rnd_shift(input logic signed [31:0] v, input int sh);
        logic signed [31:0] half;
        half = 32'sd1 <<< (sh - 1);
        return (v + half) >>> sh;
    endfunction

    // Full-precision signed product
    function automatic logic signed [31:0] mul_ext(input smp_t a, input smp_t b);
        logic signed [31:0] ea;
        logic signed [31:0] eb;
        ea = 32'(a);
        eb = 32'(b);
        return ea * eb;
    endfunction

endpackage

// File: rtl/dlms_hist.sv
`timescale 1ns/1ps
// Error history line: holds past error samples and taps off the feedback
// reference, the delayed error for adaptation and the delayed reference window.
module dlms_hist
    import dlms_pkg::*;
#(
    parameter int N_TAPS   = 12,
    parameter int COMP_DLY = 22
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         adv,
    input  smp_t                         din,
    output smp_t                         newest,
    output smp_t                         ref_now,
    output smp_t                         err_old,
    output logic [N_TAPS-1:0][DW-1:0]    ref_win
);

    localparam int LEN      = COMP_DLY + 2 * N_TAPS - 1;
    localparam int REF_IDX  = COMP_DLY - 1;
    localparam int ERR_IDX  = N_TAPS - 1;
    localparam int WIN_BASE = COMP_DLY + N_TAPS - 1;

    logic [LEN-1:0][DW-1:0] line_d;
    logic [LEN-1:0][DW-1:0] line_q;

    always_comb begin
        line_d = line_q;
        if (rst) begin
            line_d = '0;
        end else if (adv) begin
            line_d[0] = din;
            for (int j = 1; j < LEN; j++) begin
                line_d[j] = line_q[j-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        line_q <= line_d;
    end

    assign newest  = line_q[0];
    assign ref_now = line_q[REF_IDX];
    assign err_old = line_q[ERR_IDX];

    for (genvar g = 0; g < N_TAPS; g++) begin : g_win
        assign ref_win[g] = line_q[WIN_BASE + g];
    end

endmodule

// File: rtl/dlms_tap.sv
`timescale 1ns/1ps
// One tap unit: filter product into the partial-sum chain and
// delayed-LMS update of its own coefficient.
module dlms_tap
    import dlms_pkg::*;
#(
    parameter int MU_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [MU_W-1:0] mu,
    input  smp_t            ref_now,
    input  smp_t            err_old,
    input  smp_t            ref_old,
    input  smp_t            sum_in,
    output smp_t            sum_now
);

    typedef struct packed {
        smp_t w;
    } tap_st_t;

    tap_st_t            st_d;
    tap_st_t            st_q;
    smp_t               w_cur;
    smp_t               fir_p;
    smp_t               grad;
    logic signed [31:0] fir_full;
    logic signed [31:0] grad_full;

    always_comb begin
        w_cur     = st_q.w;
        // filter product, coefficient has FRAC fraction bits
        fir_full  = mul_ext(w_cur, ref_now);
        fir_p     = sat_dw(rnd_shift(fir_full, FRAC));
        sum_now   = sat_dw(32'(fir_p) + 32'(sum_in));
        // update term, step size applied as an arithmetic shift
        grad_full = mul_ext(err_old, ref_old);
        grad      = sat_dw(rnd_shift(grad_full, FRAC + int'(mu)));

        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (adv) begin
            st_d.w = sat_dw(32'(w_cur) + 32'(grad));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/dlms_canceller.sv
`timescale 1ns/1ps
module dlms_canceller
    import dlms_pkg::*;
#(
    parameter int N_TAPS   = 12,
    parameter int COMP_DLY = 22,
    parameter int MU_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic [MU_W-1:0]      step_shift,
    output logic signed [DW-1:0] est_o,
    output logic signed [DW-1:0] err_o,
    output logic                 out_valid
);

    localparam int CNT_W    = $clog2(N_TAPS) + 1;
    localparam int VLD_FROM = N_TAPS - 1;

    typedef struct packed {
        logic [MU_W-1:0]             mu;
        logic [CNT_W-1:0]            cnt;
        logic                        vld;
        logic [N_TAPS-1:0][DW-1:0]   sums;
    } top_st_t;

    top_st_t                   st_d;
    top_st_t                   st_q;
    smp_t                      sums_now [N_TAPS];
    smp_t                      y_now;
    smp_t                      e_now;
    smp_t                      e_last;
    smp_t                      ref_now;
    smp_t                      err_old;
    logic [N_TAPS-1:0][DW-1:0] ref_win;

    dlms_hist #(
        .N_TAPS   (N_TAPS),
        .COMP_DLY (COMP_DLY)
    ) i_hist (
        .clk     (clk),
        .rst     (rst),
        .adv     (in_valid),
        .din     (e_now),
        .newest  (e_last),
        .ref_now (ref_now),
        .err_old (err_old),
        .ref_win (ref_win)
    );

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        smp_t sum_in;
        if (g == N_TAPS - 1) begin : g_end
            assign sum_in = '0;
        end else begin : g_mid
            assign sum_in = st_q.sums[g+1];
        end

        dlms_tap #(
            .MU_W (MU_W)
        ) i_tap (
            .clk     (clk),
            .rst     (rst),
            .adv     (in_valid),
            .mu      (st_q.mu),
            .ref_now (ref_now),
            .err_old (err_old),
            .ref_old (ref_win[g]),
            .sum_in  (sum_in),
            .sum_now (sums_now[g])
        );
    end

    always_comb begin
        y_now = sums_now[0];
        e_now = sat_dw(32'(in_sample) - 32'(y_now));

        st_d = st_q;
        if (rst) begin
            st_d    = '0;
            st_d.mu = step_shift;
        end else begin
            st_d.vld = 1'b0;
            if (in_valid) begin
                for (int k = 0; k < N_TAPS; k++) begin
                    st_d.sums[k] = sums_now[k];
                end
                st_d.vld = (st_q.cnt >= CNT_W'(VLD_FROM));
                if (st_q.cnt < CNT_W'(VLD_FROM)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign est_o     = st_q.sums[0];
    assign err_o     = e_last;
    assign out_valid = st_q.vld;

endmodule

// File: rtl/dlms_canceller_chk.sv
`timescale 1ns/1ps
module dlms_canceller_chk
    import dlms_pkg::*;
#(
    parameter int N_TAPS = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_sample,
    input logic signed [DW-1:0] est_o,
    input logic signed [DW-1:0] err_o,
    input logic                 out_valid
);

    localparam int ACC_W = $clog2(N_TAPS + 1) + 1;

    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (in_valid && (acc_q < ACC_W'(N_TAPS))) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && est_o == '0 && err_o == '0)); // R1

    AST_ERR_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (err_o == sat_dw(32'($past(in_sample)) - 32'(est_o)))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(est_o) && $stable(err_o))); // R7

    AST_VALID_LATE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (acc_q >= ACC_W'(N_TAPS))); // R8

    AST_VALID_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_q >= ACC_W'(N_TAPS - 1)) |=> out_valid); // R8

endmodule

bind dlms_canceller dlms_canceller_chk #(
    .N_TAPS (N_TAPS)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .est_o     (est_o),
    .err_o     (err_o),
    .out_valid (out_valid)
);

// File: tb/test_dlms_canceller.sv
`timescale 1ns/1ps
module test_dlms_canceller;

    localparam int NT   = 12;
    localparam int CD   = 22;
    localparam int HLEN = CD + 2 * NT - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_sample = '0;
    logic [2:0]        step_shift = '0;
    logic signed [7:0] est_o;
    logic signed [7:0] err_o;
    logic              out_valid;

    dlms_canceller i_dlms_canceller (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .step_shift (step_shift),
        .est_o      (est_o),
        .err_o      (err_o),
        .out_valid  (out_valid)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        bit v;
        int est;
        int err;
    } exp_t;

    exp_t  q_exp[$];
    int    n_chk = 0;
    int    n_bad = 0;
    string tag_s = "R1";

    // sample-level reference model
    int w_m [NT];
    int s_m [NT];
    int eh_m [HLEN];
    int mu_m;
    int n_m;

    function automatic int sat8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int rsh(input int v, input int sh);
        return (v + (1 << (sh - 1))) >>> sh;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp_v);
        n_chk++;
        if (got != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp_v);
        end
    endtask

    task automatic model_reset(input int mu);
        for (int k = 0; k < NT; k++) begin
            w_m[k] = 0;
            s_m[k] = 0;
        end
        for (int j = 0; j < HLEN; j++) eh_m[j] = 0;
        mu_m = mu;
        n_m  = 0;
    endtask

    task automatic model_step(input int x);
        int   p [NT];
        int   u;
        int   ed;
        int   y;
        int   e;
        exp_t it;
        u  = eh_m[CD-1];          // R3: own error, 22 samples old
        ed = eh_m[NT-1];          // R5: error 12 samples old
        for (int k = 0; k < NT; k++) p[k] = sat8(rsh(w_m[k] * u, 7));
        y = sat8(p[0] + s_m[1]);  // R4
        e = sat8(x - y);          // R2
        for (int k = 0; k < NT - 1; k++) s_m[k] = sat8(p[k] + s_m[k+1]);
        s_m[NT-1] = p[NT-1];
        for (int k = 0; k < NT; k++)
            w_m[k] = sat8(w_m[k] + sat8(rsh(ed * eh_m[CD + NT - 1 + k], 7 + mu_m)));
        for (int j = HLEN - 1; j > 0; j--) eh_m[j] = eh_m[j-1];
        eh_m[0] = e;
        it.v   = (n_m >= NT - 1);  // R8
        it.est = y;
        it.err = e;
        q_exp.push_back(it);
        n_m++;
    endtask

    task automatic drive(input int x, input bit v);
        @(posedge clk);
        #2;
        in_valid  = v;
        in_sample = 8'(x);
        if (v) model_step(x);
    endtask

    task automatic do_reset(input int mu);
        @(posedge clk);
        #2;
        rst        = 1'b1;
        in_valid   = 1'b0;
        step_shift = 3'(mu);
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        model_reset(mu);
    endtask

    // monitor: pops the expected item for each accepted slot
    logic       prev_rst = 1'b1;
    logic       prev_inv = 1'b0;
    logic [7:0] prev_est = '0;
    logic [7:0] prev_err = '0;

    always @(negedge clk) begin
        if (prev_rst) begin
            check("R1", "est after reset", int'(est_o), 0);
            check("R1", "err after reset", int'(err_o), 0);
            check("R1", "valid after reset", int'(out_valid), 0);
        end else if (prev_inv) begin
            if (q_exp.size() == 0) begin
                check("R8", "unexpected accepted slot", 1, 0);
            end else begin
                exp_t it;
                it = q_exp.pop_front();
                check({"R8 ", tag_s}, "out_valid", int'(out_valid), int'(it.v));
                if (it.v) begin
                    check({"R4 ", tag_s}, "estimate", int'(est_o), it.est);
                    check({"R2 ", tag_s}, "error", int'(err_o), it.err);
                end
            end
        end else begin
            check("R7", "valid in idle slot", int'(out_valid), 0);
            check("R7", "est held", int'(est_o), int'($signed(prev_est)));
            check("R7", "err held", int'(err_o), int'($signed(prev_err)));
        end
        prev_rst = rst;
        prev_inv = in_valid;
        prev_est = est_o;
        prev_err = err_o;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Scenario A: moderate step, continuous stream (R3 R5 R10)
        do_reset(2);
        tag_s = "R3 R5 R10";
        for (int i = 0; i < 160; i++) drive(((i * 37) % 101) - 50 + (i % 7) * 9, 1'b1);

        // Scenario B: largest step, full-scale input (R6)
        do_reset(0);
        tag_s = "R6";
        for (int i = 0; i < 120; i++) drive(((i / 3) % 2) ? 127 : -128, 1'b1);
        repeat (3) drive(0, 1'b0);

        // Scenario C: idle gaps between samples (R7 R8)
        do_reset(5);
        tag_s = "R7 R8";
        for (int i = 0; i < 200; i++) drive(((i * 29) % 200) - 100, (i % 4 != 1) && (i % 9 != 3));

        // Scenario D: reset straight out of a run, then step_shift moved (R9)
        do_reset(7);
        tag_s = "R9";
        step_shift = 3'd0;
        for (int i = 0; i < 150; i++) begin
            if (i == 60) step_shift = 3'd3;
            drive(((i * i * 7) % 180) - 90, 1'b1);
        end
        repeat (4) drive(0, 1'b0);

        check("R8", "pending expected items", q_exp.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule